// File: doc/BRIEF.md
# Slave-Mode Serial Audio Input Port

This block receives a three-wire serial audio stream (bit clock, word clock, data) driven by an external master. It synchronizes all three lines into the system clock, finds the active edges of the bit clock, and rebuilds one 24-bit word per word-clock half. Each stereo pair is presented as one transfer on a valid/ready output.

Five static control inputs set the wire format. They select left or right justification, a one-bit delay before the MSB, which bit-clock edge samples data, and which word-clock level marks the left (A) channel. A resolution code applies to right-justified words. Left-justified uses justify=0, delay=0, normal edge and normal polarity. The common two-channel format with a one-bit offset uses justify=0, delay=1 and inverted polarity. All output words are left-aligned to bit 23.

The output side follows valid/ready rules. A pair is offered with `out_valid` high and stays unchanged until `out_ready` is seen high at a clock edge. Serial audio cannot be paused, so back-pressure cannot stall the input. When a newer pair completes while the old one is still waiting, the newer pair replaces it and the older one is lost. If a pair completes in the same cycle that the consumer takes the waiting pair, the waiting pair is delivered, the new pair is loaded, and `out_valid` stays high.

Top module: `sair_port`

## Requirements
- R1: After reset `out_valid` is 0 and both samples are 0. The half in progress at the first word-clock transition after reset, and every half before it, is discarded. No pair is produced until a complete left half and a complete right half have been received after that transition.
- R2: With `cfg_ws_inv`=0 the left channel is the half where the word clock is high. With `cfg_ws_inv`=1 the left channel is the half where the word clock is low. The first active bit-clock edge after a word-clock change is bit position 0 of the new half.
- R3: With `cfg_rjust`=0 and `cfg_dly`=0, the bit at position 0 is the MSB (output bit 23) and the following bits fill the lower positions, MSB first.
- R4: With `cfg_rjust`=0 and `cfg_dly`=1, position 0 is ignored and the MSB is taken from position 1.
- R5: In left-justified modes a half with fewer than 24 data bits leaves the missing low bits 0. Bits after the 24th are ignored. The per-half bit counter saturates at MAX_BITS (128) and does not wrap.
- R6: With delay and inverted polarity, any number of bit clocks per half is accepted. A 20-data-bit half yields the 20 received bits in bits 23..4 and zeros below.
- R7: With `cfg_rjust`=1 the last N bits of the half form the word, with N set by `cfg_res`: 00 gives 24, 01 gives 20, 10 gives 16, and the reserved code 11 acts as 24. The word is output left-aligned with zeros below.
- R8: `cfg_sck_fall`=0 samples data and word clock on rising bit-clock edges. `cfg_sck_fall`=1 samples them on falling edges.
- R9: A pair is produced when the right half ends, which is detected at the first active edge of the following left half. The left and right words are presented together, and `out_valid` is high in the cycle after completion.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high. The samples also stay unchanged unless a newer pair completes, and a newer pair replaces them. A pair completing in the same cycle as an accepted transfer is loaded, and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Serial bit clock from the external master |
| ws_in | input | 1 | Word (left/right) clock |
| sd_in | input | 1 | Serial data |
| cfg_rjust | input | 1 | 1 = right-justified words |
| cfg_dly | input | 1 | 1 = MSB one bit after the word-clock change |
| cfg_sck_fall | input | 1 | 1 = falling edge is the active bit-clock edge |
| cfg_ws_inv | input | 1 | 1 = left channel while the word clock is low |
| cfg_res | input | 2 | Right-justified resolution code |
| out_valid | output | 1 | Stereo pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| out_left | output | 24 | Left sample, left-aligned |
| out_right | output | 24 | Right sample, left-aligned |

## Verification
Completion of a new stereo pair and acceptance of the waiting pair by the consumer can occur in the same cycle. The bench first measures, from an identical stimulus run, the cycle in which a pair loads. It then holds `out_ready` low so that one pair is waiting, and raises `out_ready` for that one cycle only. The case passes only if the older pair is taken exactly once, the newer pair stays offered with `out_valid` still high, and the newer pair is taken later.

// File: rtl/sair_pkg.sv
package sair_pkg;
  localparam int SAMPLE_W_DEF = 24;
  localparam int MAX_BITS_DEF = 128;

  typedef enum logic [1:0] {
    RES_W24 = 2'b00,
    RES_W20 = 2'b01,
    RES_W16 = 2'b10,
    RES_RSV = 2'b11
  } res_e;

  function automatic int res_width(input res_e code, input int full_w);
    case (code)
      RES_W20: res_width = 20;
      RES_W16: res_width = 16;
      default: res_width = full_w;
    endcase
  endfunction
endpackage

// File: rtl/sair_sync.sv
module sair_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sair_deser.sv
module sair_deser
  import sair_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int MAX_BITS = MAX_BITS_DEF,
  localparam int CNT_W   = $clog2(MAX_BITS + 1),
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_s,
  input  logic                ws_s,
  input  logic                sd_s,
  input  logic                cfg_rjust,
  input  logic                cfg_dly,
  input  logic                cfg_sck_fall,
  input  logic                cfg_ws_inv,
  input  logic [1:0]          cfg_res,
  output logic                frame_done,
  output logic [SAMPLE_W-1:0] frame_l,
  output logic [SAMPLE_W-1:0] frame_r,
  output logic [CNT_W-1:0]    bit_cnt
);
  logic                sck_q;
  logic                ws_last;
  logic                have_ws;
  logic                armed;
  logic                cur_left;
  logic                a_ok;
  logic [CNT_W-1:0]    pos;
  logic [SAMPLE_W-1:0] lj_word;
  logic [SAMPLE_W-1:0] rj_sr;
  logic [SAMPLE_W-1:0] hold_l;

  logic                act;
  logic                chg;
  logic                left_new;
  logic [CNT_W-1:0]    pos_next;
  logic [SAMPLE_W-1:0] lj_next;
  logic [SAMPLE_W-1:0] rj_next;
  logic [SAMPLE_W-1:0] rj_aligned;
  logic [SAMPLE_W-1:0] done_val;

  // active edge, channel change and next word state
  always_comb begin
    int p;
    int idx;
    act      = cfg_sck_fall ? (sck_q & ~sck_s) : (~sck_q & sck_s);
    chg      = have_ws && (ws_s != ws_last);
    left_new = ws_s ^ cfg_ws_inv;
    p        = chg ? 0 : int'(pos);
    idx      = p - int'(cfg_dly);
    lj_next  = chg ? '0 : lj_word;
    if (idx >= 0 && idx < SAMPLE_W)
      lj_next[IDX_W'(SAMPLE_W - 1 - idx)] = sd_s;
    rj_next  = chg ? {{(SAMPLE_W-1){1'b0}}, sd_s} : {rj_sr[SAMPLE_W-2:0], sd_s};
    if (chg)                          pos_next = CNT_W'(1);
    else if (pos == CNT_W'(MAX_BITS)) pos_next = pos;
    else                              pos_next = pos + CNT_W'(1);
    rj_aligned = rj_sr << (SAMPLE_W - res_width(res_e'(cfg_res), SAMPLE_W));
    done_val   = cfg_rjust ? rj_aligned : lj_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      ws_last    <= 1'b0;
      have_ws    <= 1'b0;
      armed      <= 1'b0;
      cur_left   <= 1'b0;
      a_ok       <= 1'b0;
      pos        <= '0;
      lj_word    <= '0;
      rj_sr      <= '0;
      hold_l     <= '0;
      frame_done <= 1'b0;
      frame_l    <= '0;
      frame_r    <= '0;
    end else begin
      sck_q      <= sck_s;
      frame_done <= 1'b0;
      if (act) begin
        ws_last <= ws_s;
        have_ws <= 1'b1;
        lj_word <= lj_next;
        rj_sr   <= rj_next;
        pos     <= pos_next;
        if (chg) begin
          armed    <= 1'b1;
          cur_left <= left_new;
          if (armed) begin
            if (cur_left) begin
              hold_l <= done_val;
              a_ok   <= 1'b1;
            end else if (a_ok) begin
              frame_done <= 1'b1;
              frame_l    <= hold_l;
              frame_r    <= done_val;
              a_ok       <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign bit_cnt = pos;
endmodule

// File: rtl/sair_hold.sv
module sair_hold #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  input  logic                ready,
  output logic                valid,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      out_l <= '0;
      out_r <= '0;
    end else if (load) begin
      valid <= 1'b1;
      out_l <= in_l;
      out_r <= in_r;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sair_port.sv
module sair_port
  import sair_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int MAX_BITS = MAX_BITS_DEF,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_in,
  input  logic                ws_in,
  input  logic                sd_in,
  input  logic                cfg_rjust,
  input  logic                cfg_dly,
  input  logic                cfg_sck_fall,
  input  logic                cfg_ws_inv,
  input  logic [1:0]          cfg_res,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  logic [2:0]          line_s;
  logic                done_w;
  logic [SAMPLE_W-1:0] fl_w;
  logic [SAMPLE_W-1:0] fr_w;
  logic [CNT_W-1:0]    cnt_w;

  sair_sync #(.W(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({sck_in, ws_in, sd_in}),
    .d_sync  (line_s)
  );

  sair_deser #(.SAMPLE_W(SAMPLE_W), .MAX_BITS(MAX_BITS)) u_deser (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_s        (line_s[2]),
    .ws_s         (line_s[1]),
    .sd_s         (line_s[0]),
    .cfg_rjust    (cfg_rjust),
    .cfg_dly      (cfg_dly),
    .cfg_sck_fall (cfg_sck_fall),
    .cfg_ws_inv   (cfg_ws_inv),
    .cfg_res      (cfg_res),
    .frame_done   (done_w),
    .frame_l      (fl_w),
    .frame_r      (fr_w),
    .bit_cnt      (cnt_w)
  );

  sair_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (done_w),
    .in_l  (fl_w),
    .in_r  (fr_w),
    .ready (out_ready),
    .valid (out_valid),
    .out_l (out_left),
    .out_r (out_right)
  );
endmodule

// File: rtl/sair_port_chk.sv
module sair_port_chk #(
  parameter int SAMPLE_W = 24,
  parameter int MAX_BITS = 128,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                frame_done,
  input logic [CNT_W-1:0]    bit_cnt
);
  // R9
  load_shows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid);

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !frame_done |=> $stable(out_left) && $stable(out_right));

  // R10
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frame_done |=> !out_valid);

  // R5
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(MAX_BITS));
endmodule

bind sair_port sair_port_chk #(.SAMPLE_W(SAMPLE_W), .MAX_BITS(MAX_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_left   (out_left),
  .out_right  (out_right),
  .frame_done (done_w),
  .bit_cnt    (cnt_w)
);

// File: tb/test_sair_port.sv
module test_sair_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
  logic        cfg_rjust = 1'b0, cfg_dly = 1'b0, cfg_sck_fall = 1'b0, cfg_ws_inv = 1'b0;
  logic [1:0]  cfg_res = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left, out_right;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rdy_mode = 0;   // 0 always ready, 1 never, 2 only when cyc == tgt
  int tgt = -1;
  int acc_n = 0;
  logic [23:0] acc_l [0:63];
  logic [23:0] acc_r [0:63];
  bit done_flag = 0;

  always #2 clk = ~clk;

  sair_port i_sair_port (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .cfg_rjust(cfg_rjust), .cfg_dly(cfg_dly), .cfg_sck_fall(cfg_sck_fall),
    .cfg_ws_inv(cfg_ws_inv), .cfg_res(cfg_res), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  // ready driver and transfer log, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = 1'b0;
        default: out_ready = (cyc == tgt);
      endcase
      if (out_valid && out_ready && acc_n < 64) begin
        acc_l[acc_n] = out_left;
        acc_r[acc_n] = out_right;
        acc_n++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic rj, input logic dly, input logic fall,
                          input logic inv, input logic [1:0] res);
    rst_n = 1'b0;
    cfg_rjust = rj; cfg_dly = dly; cfg_sck_fall = fall; cfg_ws_inv = inv; cfg_res = res;
    sck_in = fall; ws_in = inv; sd_in = 1'b0;
    rdy_mode = 0;
    step(4);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic bit1(input logic w, input logic d);
    sck_in = cfg_sck_fall;
    #8;
    ws_in = w; sd_in = d;
    #8;
    sck_in = ~cfg_sck_fall;
    #24;
  endtask

  task automatic send_half(input logic is_left, input logic [63:0] pat, input int n);
    for (int i = 0; i < n; i++) bit1(is_left ^ ~cfg_ws_inv ^ 1'b1 ? 1'b0 : 1'b0, 1'b0);
  endtask

  // word-clock level for a channel: left is ws = ~inv, right is ws = inv
  task automatic half(input logic is_left, input logic [63:0] pat, input int n);
    logic lvl;
    lvl = is_left ? ~cfg_ws_inv : cfg_ws_inv;
    for (int i = 0; i < n; i++) bit1(lvl, pat[63-i]);
  endtask

  function automatic logic [63:0] lj_pat(input logic [23:0] w, input logic dly);
    lj_pat = {w, 40'h0} >> dly;
  endfunction

  function automatic logic [63:0] rj_pat(input logic [23:0] w, input int n);
    rj_pat = {40'h0, w} << (64 - n);
  endfunction

  task automatic finish_pairs();
    half(1'b1, 64'h0, 2);
    step(30);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset(0, 0, 0, 0, 2'b00);
    chk("R1 reset valid", {31'h0, out_valid}, 32'h0);
    chk("R1 reset left", {8'h0, out_left}, 32'h0);
    chk("R1 reset right", {8'h0, out_right}, 32'h0);
  endtask

  // R1 and R9: first partial period is discarded
  task automatic t_startup();
    int b;
    do_reset(0, 0, 0, 0, 2'b00);
    b = acc_n;
    half(1'b1, lj_pat(24'h111111, 0), 6);
    half(1'b0, lj_pat(24'h222222, 0), 32);
    half(1'b1, lj_pat(24'hA5C3F1, 0), 32);
    half(1'b0, lj_pat(24'h3C5A96, 0), 32);
    finish_pairs();
    chk("R1 pairs after startup", acc_n - b, 1);
    chk("R9 left of first pair", {8'h0, acc_l[b]}, {8'h0, 24'hA5C3F1});
    chk("R9 right of first pair", {8'h0, acc_r[b]}, {8'h0, 24'h3C5A96});
  endtask

  // R3 and R2: left-justified, two pairs
  task automatic t_lj();
    int b;
    do_reset(0, 0, 0, 0, 2'b00);
    b = acc_n;
    half(1'b0, 64'h0, 5);
    half(1'b1, lj_pat(24'h812345, 0), 32);
    half(1'b0, lj_pat(24'h7EDCBA, 0), 32);
    half(1'b1, lj_pat(24'h000001, 0), 28);
    half(1'b0, lj_pat(24'hFFFFFE, 0), 40);
    finish_pairs();
    chk("R2 pair count", acc_n - b, 2);
    chk("R3 left word", {8'h0, acc_l[b]}, {8'h0, 24'h812345});
    chk("R3 right word", {8'h0, acc_r[b]}, {8'h0, 24'h7EDCBA});
    chk("R3 left lsb only", {8'h0, acc_l[b+1]}, {8'h0, 24'h000001});
    chk("R5 extra bits ignored", {8'h0, acc_r[b+1]}, {8'h0, 24'hFFFFFE});
  endtask

  // R4, R2 and R6: delayed MSB with inverted word clock
  task automatic t_i2s();
    int b;
    do_reset(0, 1, 0, 1, 2'b00);
    b = acc_n;
    half(1'b0, 64'h0, 3);
    half(1'b1, lj_pat(24'hC0FFEE, 1), 32);
    half(1'b0, lj_pat(24'h13579B, 1), 32);
    half(1'b1, lj_pat(24'hABCDEF, 1), 21);
    half(1'b0, lj_pat(24'h2468AC, 1), 30);
    finish_pairs();
    chk("R2 pair count inverted", acc_n - b, 2);
    chk("R4 left delayed", {8'h0, acc_l[b]}, {8'h0, 24'hC0FFEE});
    chk("R4 right delayed", {8'h0, acc_r[b]}, {8'h0, 24'h13579B});
    chk("R6 20-bit half", {8'h0, acc_l[b+1]}, {8'h0, 24'hABCDE0});
    chk("R6 30-clock half", {8'h0, acc_r[b+1]}, {8'h0, 24'h2468AC});
  endtask

  // R5: short left-justified words
  task automatic t_short();
    int b;
    do_reset(0, 0, 0, 0, 2'b00);
    b = acc_n;
    half(1'b0, 64'h0, 4);
    half(1'b1, lj_pat(24'h9ABCDE, 0), 16);
    half(1'b0, lj_pat(24'h5A5A5A, 0), 20);
    finish_pairs();
    chk("R5 16-bit left", {8'h0, acc_l[b]}, {8'h0, 24'h9ABC00});
    chk("R5 20-bit right", {8'h0, acc_r[b]}, {8'h0, 24'h5A5A50});
  endtask

  // R7: right-justified at each resolution code
  task automatic t_rj(input logic [1:0] res, input logic [23:0] exp_l, input logic [23:0] exp_r);
    int b;
    do_reset(1, 0, 0, 0, res);
    b = acc_n;
    half(1'b0, 64'h0, 4);
    half(1'b1, rj_pat(24'hF3B1D7, 32), 32);
    half(1'b0, rj_pat(24'h6E2C48, 40), 40);
    finish_pairs();
    chk("R7 rj left", {8'h0, acc_l[b]}, {8'h0, exp_l});
    chk("R7 rj right", {8'h0, acc_r[b]}, {8'h0, exp_r});
  endtask

  // R8: falling active edge
  task automatic t_fall();
    int b;
    do_reset(0, 0, 1, 0, 2'b00);
    b = acc_n;
    half(1'b0, 64'h0, 4);
    half(1'b1, lj_pat(24'hB4D2F0, 0), 32);
    half(1'b0, lj_pat(24'h0F1E2D, 0), 32);
    finish_pairs();
    chk("R8 falling edge left", {8'h0, acc_l[b]}, {8'h0, 24'hB4D2F0});
    chk("R8 falling edge right", {8'h0, acc_r[b]}, {8'h0, 24'h0F1E2D});
  endtask

  // R10: held pair is replaced by the newer one
  task automatic t_hold();
    int b;
    do_reset(0, 0, 0, 0, 2'b00);
    rdy_mode = 1;
    b = acc_n;
    half(1'b0, 64'h0, 4);
    half(1'b1, lj_pat(24'h111AAA, 0), 32);
    half(1'b0, lj_pat(24'h222BBB, 0), 32);
    half(1'b1, lj_pat(24'h333CCC, 0), 32);
    half(1'b0, lj_pat(24'h444DDD, 0), 32);
    finish_pairs();
    chk("R10 valid held", {31'h0, out_valid}, 32'h1);
    chk("R10 newer left", {8'h0, out_left}, {8'h0, 24'h333CCC});
    step(40);
    chk("R10 right stable", {8'h0, out_right}, {8'h0, 24'h444DDD});
    rdy_mode = 0;
    step(5);
    chk("R10 one transfer", acc_n - b, 1);
    chk("R10 transferred pair", {8'h0, acc_r[b]}, {8'h0, 24'h444DDD});
    chk("R10 valid clears", {31'h0, out_valid}, 32'h0);
  endtask

  // R10: load and transfer in the same cycle
  task automatic t_collide();
    int b, c0, lat;
    do_reset(0, 0, 0, 0, 2'b00);
    rdy_mode = 1;
    half(1'b0, 64'h0, 4);
    half(1'b1, lj_pat(24'hA1A1A1, 0), 32);
    half(1'b0, lj_pat(24'hB2B2B2, 0), 32);
    c0 = cyc;
    fork
      half(1'b1, 64'h0, 2);
      begin
        while (!out_valid) step(1);
      end
    join
    lat = 0;
    // measure load cycle relative to the start of the closing half
    do_reset(0, 0, 0, 0, 2'b00);
    rdy_mode = 1;
    half(1'b0, 64'h0, 4);
    half(1'b1, lj_pat(24'hA1A1A1, 0), 32);
    half(1'b0, lj_pat(24'hB2B2B2, 0), 32);
    begin
      int c1;
      c1 = cyc;
      fork
        half(1'b1, lj_pat(24'hC3C3C3, 0), 32);
        begin
          while (!out_valid) step(1);
          lat = cyc - c1;
        end
      join
    end
    half(1'b0, lj_pat(24'hD4D4D4, 0), 32);
    b = acc_n;
    tgt = cyc + lat;
    rdy_mode = 2;
    half(1'b1, 64'h0, 2);
    step(30);
    chk("R10 older taken once", acc_n - b, 1);
    chk("R10 older pair", {8'h0, acc_l[b]}, {8'h0, 24'hA1A1A1});
    chk("R10 valid kept on collide", {31'h0, out_valid}, 32'h1);
    chk("R10 newer offered", {8'h0, out_left}, {8'h0, 24'hC3C3C3});
    rdy_mode = 0;
    step(5);
    chk("R10 newer taken", {8'h0, acc_r[b+1]}, {8'h0, 24'hD4D4D4});
    if (c0 < 0) n_fail++;
  endtask

  initial begin
    t_reset();
    t_startup();
    t_lj();
    t_i2s();
    t_short();
    t_rj(2'b00, 24'hF3B1D7, 24'h6E2C48);
    t_rj(2'b01, 24'h3B1D70, 24'hE2C480);
    t_rj(2'b10, 24'hB1D700, 24'h2C4800);
    t_rj(2'b11, 24'hF3B1D7, 24'h6E2C48);
    t_fall();
    t_hold();
    t_collide();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!done_flag) begin
      done_flag = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule